// File: doc/BRIEF.md
# Cascaded Programmable Reference Divider

This block turns a free-running oscillator clock into a low-rate reference for a phase comparator. Two divide stages sit in series. A prescaler divides the oscillator by 4 or 5, and a postscaler divides the prescaler's terminal ticks by 2, 4 or 8. The reference therefore runs at the oscillator rate divided by one of 8, 10, 16, 20, 32 or 40. The oscillator rate is chosen from the target shaft speed: the ratio times the revolutions per minute divided by sixty, times the pole pairs, and doubled when both feedback edges are sensed. The prescaler must run at oscillator rates up to 10 MHz, which the single-clock design meets easily.

Each stage is a two-state machine. The prescaler holds `STG_RUN` while it counts. It goes from `STG_RUN` to `STG_TERM` when its count reaches its ratio minus one, and from `STG_TERM` back to `STG_RUN` on the next cycle, clearing the count and loading its ratio again from its select. The postscaler holds `STG_RUN` while it counts prescaler ticks. It goes from `STG_RUN` to `STG_LAST` on the tick that brings its count to its ratio minus one. On the next tick it goes from `STG_LAST` back to `STG_RUN`, firing the final terminal count, clearing the count and loading its ratio. Because each stage loads its ratio only at its own wrap, changing a select never cuts a period short. The output stage registers a one-cycle strobe at each final terminal count and toggles a square wave on the same cycle.

Top module: `ref_divider_chain`

## Requirements
- R1: While `rst` is high at a clock edge, both stages return to `STG_RUN` with zero counts, and both outputs read 0 after that edge. The first strobe appears after exactly N rising edges with `rst` low, where N is the selected overall ratio.
- R2: The prescaler divides by 4 when `pre_div4_sel` is 1 and by 5 when it is 0.
- R3: The postscaler divides by 2 for `post_div_sel` = 2'b00, by 4 for 2'b01 (the default code), and by 8 for 2'b10.
- R4: The code 2'b11 on `post_div_sel` divides by 4.
- R5: Strobes repeat every N cycles, where N is the product of the two stage ratios: one of 8, 10, 16, 20, 32 or 40.
- R6: `ref_strobe` is high for exactly one clock cycle at each final terminal count.
- R7: `ref_square` toggles on exactly the cycles where `ref_strobe` is high and holds its value otherwise, so its period is 2N.
- R8: A new `post_div_sel` takes effect only after the postscaler's current count has wrapped. A change made just after a strobe leaves the next period at the old ratio.
- R9: A new `pre_div4_sel` takes effect at the prescaler's next wrap. A change made just after a strobe gives a next period of (old prescale) + (postscale - 1) × (new prescale).
- R10: Asserting `rst` mid-period clears the outputs and restarts the count, so the next strobe is N cycles after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; every rising edge is one oscillator cycle |
| rst | input | 1 | Synchronous reset, active high |
| pre_div4_sel | input | 1 | Prescaler select: 1 divides by 4, 0 divides by 5 |
| post_div_sel | input | 2 | Postscaler select: 00 divides by 2, 01 or 11 divides by 4, 10 divides by 8 |
| ref_strobe | output | 1 | One-cycle pulse at each final terminal count |
| ref_square | output | 1 | Square wave that toggles on each strobe |

## Verification
All eight select combinations are run from reset. The six distinct ratios show that each stage decodes its own select and that the stage ratios multiply rather than add. Running code 2'b11 next to code 2'b01 shows that the spare code acts as divide by 4. Changing the postscaler select and the prescaler select separately, just after a strobe, yields period lengths that differ only if each stage defers its new ratio to its own wrap. A reset asserted mid-period, after the square wave has gone high, shows that the restart clears the count and the wave alike.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    // Two-state control used by both divide stages.
    typedef enum logic [1:0] {
        STG_RUN  = 2'b00,
        STG_TERM = 2'b01,
        STG_LAST = 2'b10
    } stage_state_e;

    // Postscaler select codes.
    typedef enum logic [1:0] {
        POST_CODE_DIV2 = 2'b00,
        POST_CODE_DIV4 = 2'b01,
        POST_CODE_DIV8 = 2'b10,
        POST_CODE_SPARE = 2'b11
    } post_code_e;

    // Width needed to hold a value up to max_val.
    function automatic int width_for(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/refdiv_prescaler.sv
module refdiv_prescaler
    import refdiv_pkg::*;
#(
    parameter int RATIO_SEL_HI = 4,
    parameter int RATIO_SEL_LO = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_hi,
    output logic tick
);

    localparam int MAX_RATIO = (RATIO_SEL_HI > RATIO_SEL_LO) ? RATIO_SEL_HI : RATIO_SEL_LO;
    localparam int RW        = width_for(MAX_RATIO);

    stage_state_e     state_q, state_d;
    logic [RW-1:0]    count_q, count_d;
    logic [RW-1:0]    ratio_q, ratio_d;
    logic [RW-1:0]    sel_ratio;

    // Ratio requested by the select input right now.
    always_comb begin
        sel_ratio = sel_hi ? RW'(RATIO_SEL_HI) : RW'(RATIO_SEL_LO);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= STG_RUN;
            count_q <= '0;
            ratio_q <= sel_ratio;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            ratio_q <= ratio_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        ratio_d = ratio_q;
        unique case (state_q)
            STG_RUN: begin
                count_d = count_q + RW'(1);
                if (count_q == ratio_q - RW'(2)) begin
                    state_d = STG_TERM;
                end
            end
            STG_TERM: begin
                count_d = '0;
                ratio_d = sel_ratio;
                state_d = STG_RUN;
            end
            default: begin
                count_d = '0;
                ratio_d = sel_ratio;
                state_d = STG_RUN;
            end
        endcase
    end

    // Output logic.
    always_comb begin
        tick = (state_q == STG_TERM);
    end

endmodule

// File: rtl/refdiv_postscaler.sv
module refdiv_postscaler
    import refdiv_pkg::*;
#(
    parameter int RATIO_CODE_A = 2,
    parameter int RATIO_CODE_B = 4,
    parameter int RATIO_CODE_C = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_in,
    input  logic [1:0] sel,
    output logic       fire
);

    localparam int MAX_AB    = (RATIO_CODE_A > RATIO_CODE_B) ? RATIO_CODE_A : RATIO_CODE_B;
    localparam int MAX_RATIO = (MAX_AB > RATIO_CODE_C) ? MAX_AB : RATIO_CODE_C;
    localparam int RW        = width_for(MAX_RATIO);

    stage_state_e     state_q, state_d;
    logic [RW-1:0]    count_q, count_d;
    logic [RW-1:0]    ratio_q, ratio_d;
    logic [RW-1:0]    sel_ratio;
    post_code_e       code;

    // Decode the select; the spare code falls back to the middle ratio.
    always_comb begin
        code = post_code_e'(sel);
        unique case (code)
            POST_CODE_DIV2:  sel_ratio = RW'(RATIO_CODE_A);
            POST_CODE_DIV4:  sel_ratio = RW'(RATIO_CODE_B);
            POST_CODE_DIV8:  sel_ratio = RW'(RATIO_CODE_C);
            POST_CODE_SPARE: sel_ratio = RW'(RATIO_CODE_B);
            default:         sel_ratio = RW'(RATIO_CODE_B);
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= STG_RUN;
            count_q <= '0;
            ratio_q <= sel_ratio;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            ratio_q <= ratio_d;
        end
    end

    // Next-state logic: advances only on prescaler ticks.
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        ratio_d = ratio_q;
        unique case (state_q)
            STG_RUN: begin
                if (tick_in) begin
                    count_d = count_q + RW'(1);
                    if (count_q == ratio_q - RW'(2)) begin
                        state_d = STG_LAST;
                    end
                end
            end
            STG_LAST: begin
                if (tick_in) begin
                    count_d = '0;
                    ratio_d = sel_ratio;
                    state_d = STG_RUN;
                end
            end
            default: begin
                count_d = '0;
                ratio_d = sel_ratio;
                state_d = STG_RUN;
            end
        endcase
    end

    // Output logic.
    always_comb begin
        fire = (state_q == STG_LAST) && tick_in;
    end

endmodule

// File: rtl/refdiv_output.sv
module refdiv_output (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic strobe,
    output logic square
);

    logic strobe_q;
    logic square_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            square_q <= 1'b0;
        end else begin
            strobe_q <= fire;
            square_q <= square_q ^ fire;
        end
    end

    always_comb begin
        strobe = strobe_q;
        square = square_q;
    end

endmodule

// File: rtl/ref_divider_chain.sv
module ref_divider_chain #(
    parameter int PRE_RATIO_SEL_HI  = 4,
    parameter int PRE_RATIO_SEL_LO  = 5,
    parameter int POST_RATIO_CODE_A = 2,
    parameter int POST_RATIO_CODE_B = 4,
    parameter int POST_RATIO_CODE_C = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pre_div4_sel,
    input  logic [1:0] post_div_sel,
    output logic       ref_strobe,
    output logic       ref_square
);

    logic pre_tick;
    logic final_fire;

    refdiv_prescaler #(
        .RATIO_SEL_HI (PRE_RATIO_SEL_HI),
        .RATIO_SEL_LO (PRE_RATIO_SEL_LO)
    ) u_pre (
        .clk    (clk),
        .rst    (rst),
        .sel_hi (pre_div4_sel),
        .tick   (pre_tick)
    );

    refdiv_postscaler #(
        .RATIO_CODE_A (POST_RATIO_CODE_A),
        .RATIO_CODE_B (POST_RATIO_CODE_B),
        .RATIO_CODE_C (POST_RATIO_CODE_C)
    ) u_post (
        .clk     (clk),
        .rst     (rst),
        .tick_in (pre_tick),
        .sel     (post_div_sel),
        .fire    (final_fire)
    );

    refdiv_output u_out (
        .clk    (clk),
        .rst    (rst),
        .fire   (final_fire),
        .strobe (ref_strobe),
        .square (ref_square)
    );

endmodule

// File: rtl/refdiv_checker.sv
module refdiv_checker #(
    parameter int MIN_RATIO = 8,
    parameter int MAX_RATIO = 40
) (
    input logic clk,
    input logic rst,
    input logic pre_tick,
    input logic ref_strobe,
    input logic ref_square
);

    logic       armed_q;
    logic [7:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b1;
            gap_q   <= '0;
        end else if (ref_strobe) begin
            gap_q <= 8'd1;
        end else if (gap_q != 8'hFF) begin
            gap_q <= gap_q + 8'd1;
        end
    end

    // R1: outputs are quiet in the cycle after a reset edge.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!ref_strobe && !ref_square));

    // R2: the prescaler tick never lasts two cycles.
    assert_pre_tick_single_R2: assert property (@(posedge clk) disable iff (rst || !armed_q)
        pre_tick |=> !pre_tick);

    // R5: strobe spacing stays within the legal ratio range.
    assert_gap_bounds_R5: assert property (@(posedge clk) disable iff (rst || !armed_q)
        ref_strobe |-> (gap_q >= 8'(MIN_RATIO) && gap_q <= 8'(MAX_RATIO)));

    // R5: no strobe is overdue.
    assert_not_overdue_R5: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !ref_strobe |-> (gap_q < 8'(MAX_RATIO)));

    // R6: the strobe is a single-cycle pulse.
    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (rst || !armed_q)
        ref_strobe |=> !ref_strobe);

    // R7: the square wave changes exactly when the strobe is high.
    assert_square_follows_R7: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !$past(rst) |-> ((ref_square != $past(ref_square)) == ref_strobe));

endmodule

bind ref_divider_chain refdiv_checker #(
    .MIN_RATIO (8),
    .MAX_RATIO (40)
) u_refdiv_checker (
    .clk        (clk),
    .rst        (rst),
    .pre_tick   (pre_tick),
    .ref_strobe (ref_strobe),
    .ref_square (ref_square)
);

// File: tb/ref_divider_chain_bench.sv
`timescale 1ns/1ps
module ref_divider_chain_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pre_div4_sel = 1'b1;
    logic [1:0] post_div_sel = 2'b01;
    logic       ref_strobe;
    logic       ref_square;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    ref_divider_chain u_ref_divider_chain (
        .clk          (clk),
        .rst          (rst),
        .pre_div4_sel (pre_div4_sel),
        .post_div_sel (post_div_sel),
        .ref_strobe   (ref_strobe),
        .ref_square   (ref_square)
    );

    function automatic int pre_ratio(input logic s);
        return s ? 4 : 5;
    endfunction

    function automatic int post_ratio(input logic [1:0] c);
        case (c)
            2'b00:   return 2;
            2'b10:   return 8;
            default: return 4;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count negedges until a strobe is seen; also flags square changes without a strobe.
    task automatic wait_strobe(output int cnt, output int sq_bad);
        logic last_sq;
        last_sq = ref_square;
        cnt = 0;
        sq_bad = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            cnt++;
            if (!ref_strobe && ref_square != last_sq) sq_bad++;
            if (ref_strobe && ref_square == last_sq) sq_bad++;
            last_sq = ref_square;
            if (ref_strobe) break;
        end
    endtask

    task automatic do_reset(input logic pre, input logic [1:0] post);
        @(negedge clk);
        rst = 1'b1;
        pre_div4_sel = pre;
        post_div_sel = post;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset(1'b1, 2'b01);
        rst = 1'b1;
        @(negedge clk);
        check(ref_strobe == 1'b0, "R1 strobe in reset", ref_strobe, 0);
        check(ref_square == 1'b0, "R1 square in reset", ref_square, 0);
        rst = 1'b0;
    endtask

    task automatic t_ratio(input logic pre, input logic [1:0] post, input string req);
        int n, cnt, bad;
        n = pre_ratio(pre) * post_ratio(post);
        do_reset(pre, post);
        wait_strobe(cnt, bad);
        check(cnt == n, {req, " R1 first strobe"}, cnt, n);
        check(ref_square == 1'b1, {req, " R7 square after first strobe"}, ref_square, 1);
        wait_strobe(cnt, bad);
        check(cnt == n, {req, " R5 period"}, cnt, n);
        check(bad == 0, {req, " R6 R7 strobe/square shape"}, bad, 0);
        check(ref_square == 1'b0, {req, " R7 square after second strobe"}, ref_square, 0);
    endtask

    task automatic t_post_change();
        int cnt, bad;
        do_reset(1'b1, 2'b00);
        wait_strobe(cnt, bad);
        post_div_sel = 2'b10;
        wait_strobe(cnt, bad);
        check(cnt == 8, "R8 period after post change keeps old ratio", cnt, 8);
        wait_strobe(cnt, bad);
        check(cnt == 32, "R8 period with new post ratio", cnt, 32);
    endtask

    task automatic t_pre_change();
        int cnt, bad;
        do_reset(1'b1, 2'b00);
        wait_strobe(cnt, bad);
        pre_div4_sel = 1'b0;
        wait_strobe(cnt, bad);
        check(cnt == 9, "R9 mixed period after pre change", cnt, 9);
        wait_strobe(cnt, bad);
        check(cnt == 10, "R9 period with new pre ratio", cnt, 10);
    endtask

    task automatic t_mid_reset();
        int cnt, bad;
        do_reset(1'b0, 2'b01);
        wait_strobe(cnt, bad);
        for (int i = 0; i < 7; i++) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(ref_square == 1'b0, "R10 square cleared by reset", ref_square, 0);
        check(ref_strobe == 1'b0, "R10 strobe cleared by reset", ref_strobe, 0);
        rst = 1'b0;
        wait_strobe(cnt, bad);
        check(cnt == 20, "R10 restart period", cnt, 20);
    endtask

    initial begin
        t_reset_state();
        t_ratio(1'b1, 2'b00, "R2 R3 div8");
        t_ratio(1'b0, 2'b00, "R2 R3 div10");
        t_ratio(1'b1, 2'b01, "R3 div16");
        t_ratio(1'b0, 2'b01, "R3 div20");
        t_ratio(1'b1, 2'b10, "R3 div32");
        t_ratio(1'b0, 2'b10, "R5 div40");
        t_ratio(1'b1, 2'b11, "R4 spare div16");
        t_ratio(1'b0, 2'b11, "R4 spare div20");
        t_post_change();
        t_pre_change();
        t_mid_reset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule